// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block watches the address strobe, function code and selected address lines of a 68000-style bus and recognises interrupt acknowledge cycles without any outside decode logic. When the processor acknowledges priority level 4, the block answers on its own. It drives an 8-bit vector number on the data bus and asserts its data-transfer acknowledge. The three high bits of that vector come from a programmable vector-base register. The five low bits encode the highest-numbered internal source that is pending, and read 00000 when nothing is pending.

For priority levels 1, 6 and 7, outside devices answer the acknowledge. They return either their own vector (with their own DTACK) or an autovector request. To spare those devices the decode, the block drives one active-low acknowledge strobe pin for each of these three levels. Each pin has an enable bit in a pin-control register. A disabled pin works as a plain output driven from a data bit in the same register. When a level-4 acknowledge sees the autovector input asserted, the block raises a protocol-error flag.

Top module: `iack_vector_unit`

## Requirements
- R1: After reset the vector-base bits are 000, all three strobe enables are off, the general-purpose pin bits are 0 (so `ackPinN` reads 3'b000), `dtackN` is 1, `dataOe` is 0 and `avecErr` is 0.
- R2: An acknowledge cycle is recognised only when `asN` is 0, `fc` is 3'b111 and `addrHi` is 4'b1111. The acknowledged level is `addrLo`. Any other bus cycle gets no response on any output.
- R3: For a level-4 acknowledge, one clock after detection `dataOe` is 1, `dtackN` is 0, and `dataOut` = {vector-base[2:0], code[4:0]}. Here code is the index of the highest-numbered bit set in `srcReq`, so bit 31 wins.
- R4: For a level-4 acknowledge while `srcReq` is all zero, the low five bits of `dataOut` are 00000.
- R5: The vector is captured in the clock that detects the cycle. Changes on `srcReq` during the cycle leave `dataOut` unchanged until the cycle ends.
- R6: In the same cycle that `asN` returns to 1, `dtackN` goes to 1 and `dataOe` goes to 0.
- R7: During an acknowledge of level 1, 6 or 7, the matching enabled strobe pin goes low. Pin index 0 is level 1, index 1 is level 6 and index 2 is level 7. An enabled strobe pin idles high. The block never asserts `dtackN` or `dataOe` for these levels.
- R8: Register writes use `regWrEn`. With `regSel`=0 the write sets the vector base from `regWrData[7:5]`. With `regSel`=1 the write sets the strobe enables from `regWrData[2:0]` and the general-purpose pin values from `regWrData[5:3]`, using the same pin order as R7. A pin whose enable is 0 shows its general-purpose bit and ignores acknowledge cycles.
- R9: Acknowledges of levels 0, 2, 3 and 5 drive no strobe, no data and no DTACK.
- R10: `avecErr` is 1 while a level-4 acknowledge is active and `avecN` is 0. It stays 0 for the other levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| asN | input | 1 | Bus address strobe, active low |
| fc | input | 3 | Bus function code |
| addrHi | input | 4 | Address bits 19..16 |
| addrLo | input | 3 | Address bits 3..1, the acknowledged level |
| avecN | input | 1 | Autovector request, active low |
| srcReq | input | 32 | Pending internal interrupt sources |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0: vector-base register, 1: pin-control register |
| regWrData | input | 8 | Register write data |
| dataOut | output | 8 | Vector driven on data bits 7..0 |
| dataOe | output | 1 | Data bus drive enable |
| dtackN | output | 1 | Internal data-transfer acknowledge, active low |
| ackPinN | output | 3 | Level 1/6/7 acknowledge strobes or general-purpose outputs |
| avecErr | output | 1 | Autovector asserted during a level-4 acknowledge |

## Verification
A wrong captured code or vector-base value shows on `dataOut` during the first clock that `dtackN` is low, one clock after the acknowledge is detected. A capture register that keeps tracking its input shows as `dataOut` changing while `dtackN` stays low. A stale level register, or a state machine that does not return to idle, shows as a strobe pin or `dtackN` that is still active in the same cycle `asN` rises, or that fires on the next non-acknowledge cycle. Register-field errors show on `ackPinN` in the first idle cycle after the write.

// File: rtl/iackv_pkg.sv
package iackv_pkg;
  localparam int NUM_STRB = 3;

  typedef enum logic [0:0] {ST_IDLE, ST_ACK} ackState_e;

  typedef struct packed {
    logic                capture;
    logic                driveVec;
    logic [NUM_STRB-1:0] strobe;
  } ctlStrobes_t;
endpackage

// File: rtl/iackv_ctrl.sv
module iackv_ctrl
  import iackv_pkg::*;
#(
  parameter int FC_W      = 3,
  parameter int AHI_W     = 4,
  parameter int LVL_W     = 3,
  parameter int ACK_FC    = 7,
  parameter int ACK_AHI   = 15,
  parameter int VEC_LEVEL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             asN,
  input  logic [FC_W-1:0]  fc,
  input  logic [AHI_W-1:0] addrHi,
  input  logic [LVL_W-1:0] addrLo,
  input  logic             avecN,
  output ctlStrobes_t      ctl,
  output logic             dtackN,
  output logic             avecErr
);
  ackState_e        stateQ;
  logic [LVL_W-1:0] lvlQ;
  logic             iackHit;
  logic             busy;
  logic             isVecLvl;
  logic [NUM_STRB-1:0] strbVec;

  function automatic logic [LVL_W-1:0] strbLevel(input int k);
    case (k)
      0:       return LVL_W'(1);
      1:       return LVL_W'(6);
      default: return LVL_W'(7);
    endcase
  endfunction

  // Acknowledge decode straight from the bus lines
  assign iackHit = !asN && (fc == FC_W'(ACK_FC)) && (addrHi == AHI_W'(ACK_AHI));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      lvlQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (iackHit) begin
          stateQ <= ST_ACK;
          lvlQ   <= addrLo;
        end
        ST_ACK:  if (asN) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (stateQ == ST_ACK) && !asN;
  assign isVecLvl = (lvlQ == LVL_W'(VEC_LEVEL));

  for (genvar k = 0; k < NUM_STRB; k++) begin : gStrb
    assign strbVec[k] = busy && (lvlQ == strbLevel(k));
  end

  always_comb begin
    ctl.capture  = (stateQ == ST_IDLE) && iackHit;
    ctl.driveVec = busy && isVecLvl;
    ctl.strobe   = strbVec;
  end

  assign dtackN  = !(busy && isVecLvl);
  assign avecErr = busy && isVecLvl && !avecN;

  // R2: entry into an acknowledge only after a full decode hit
  a_r2_entry_decoded: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACK && $past(stateQ) == ST_IDLE) |->
      ($past(fc) == FC_W'(ACK_FC) && $past(addrHi) == AHI_W'(ACK_AHI) && !$past(asN)));
  // R7: at most one level strobe at a time
  a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strbVec));
  // R7: externally answered levels never get our DTACK
  a_r7_ext_no_dtack: assert property (@(posedge clk) disable iff (!rstN)
    (|strbVec) |-> dtackN);
  // R6: DTACK released once the address strobe negates
  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) |-> dtackN);
  // R10: the error flag only appears inside a vector-supplying cycle
  a_r10_err_in_vec_cycle: assert property (@(posedge clk) disable iff (!rstN)
    avecErr |-> !dtackN);
endmodule

// File: rtl/iackv_dpath.sv
module iackv_dpath
  import iackv_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int VHI_W   = 3,
  localparam int CODE_W = $clog2(NUM_SRC),
  localparam int DATA_W = VHI_W + CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [NUM_SRC-1:0]  srcReq,
  input  logic                regWrEn,
  input  logic                regSel,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  output logic [NUM_STRB-1:0] ackPinN
);
  localparam int GPIO_LSB = NUM_STRB;

  logic [VHI_W-1:0]    vecHiQ;
  logic [NUM_STRB-1:0] strbEnQ;
  logic [NUM_STRB-1:0] gpioQ;
  logic [CODE_W-1:0]   topCode;
  logic                anyReq;
  logic [DATA_W-1:0]   vecQ;

  // Register write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecHiQ  <= '0;
      strbEnQ <= '0;
      gpioQ   <= '0;
    end else if (regWrEn) begin
      if (!regSel) begin
        vecHiQ <= regWrData[DATA_W-1 -: VHI_W];
      end else begin
        strbEnQ <= regWrData[NUM_STRB-1:0];
        gpioQ   <= regWrData[GPIO_LSB +: NUM_STRB];
      end
    end
  end

  // Fixed-priority encoder: highest index wins
  always_comb begin
    topCode = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcReq[i]) topCode = CODE_W'(i);
    end
  end
  assign anyReq = |srcReq;

  // Vector captured in the detecting clock, held for the whole cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
    end else if (ctl.capture) begin
      vecQ <= {vecHiQ, (anyReq ? topCode : CODE_W'(0))};
    end
  end

  assign dataOe  = ctl.driveVec;
  assign dataOut = ctl.driveVec ? vecQ : '0;

  // Strobe pins fall back to general-purpose outputs when disabled
  for (genvar k = 0; k < NUM_STRB; k++) begin : gPin
    assign ackPinN[k] = strbEnQ[k] ? !ctl.strobe[k] : gpioQ[k];
  end

  // R5: vector does not move while it is being driven
  a_r5_vec_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.driveVec && $past(ctl.driveVec)) |-> $stable(dataOut));
  // R4: empty request set yields the error code
  a_r4_empty_code: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !anyReq) |=> (vecQ[CODE_W-1:0] == '0));
  // R3: upper vector bits come from the programmed base
  a_r3_vec_hi: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (vecQ[DATA_W-1 -: VHI_W] == $past(vecHiQ)));
endmodule

// File: rtl/iack_vector_unit.sv
module iack_vector_unit
  import iackv_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int VHI_W     = 3,
  parameter int FC_W      = 3,
  parameter int AHI_W     = 4,
  parameter int LVL_W     = 3,
  parameter int ACK_FC    = 7,
  parameter int ACK_AHI   = 15,
  parameter int VEC_LEVEL = 4,
  localparam int DATA_W   = VHI_W + $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                asN,
  input  logic [FC_W-1:0]     fc,
  input  logic [AHI_W-1:0]    addrHi,
  input  logic [LVL_W-1:0]    addrLo,
  input  logic                avecN,
  input  logic [NUM_SRC-1:0]  srcReq,
  input  logic                regWrEn,
  input  logic                regSel,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe,
  output logic                dtackN,
  output logic [NUM_STRB-1:0] ackPinN,
  output logic                avecErr
);
  ctlStrobes_t ctl;

  iackv_ctrl #(
    .FC_W(FC_W), .AHI_W(AHI_W), .LVL_W(LVL_W),
    .ACK_FC(ACK_FC), .ACK_AHI(ACK_AHI), .VEC_LEVEL(VEC_LEVEL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .asN(asN), .fc(fc), .addrHi(addrHi),
    .addrLo(addrLo), .avecN(avecN), .ctl(ctl), .dtackN(dtackN),
    .avecErr(avecErr)
  );

  iackv_dpath #(.NUM_SRC(NUM_SRC), .VHI_W(VHI_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcReq(srcReq),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .dataOut(dataOut), .dataOe(dataOe), .ackPinN(ackPinN)
  );
endmodule

// File: tb/sim_iack_vector_unit.sv
`timescale 1ns/1ps
module sim_iack_vector_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1;
  logic [2:0] fc = '0;
  logic [3:0] addrHi = '0;
  logic [2:0] addrLo = '0;
  logic avecN = 1'b1;
  logic [31:0] srcReq = '0;
  logic regWrEn = 1'b0;
  logic regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] dataOut;
  logic dataOe, dtackN, avecErr;
  logic [2:0] ackPinN;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] expQ[$];
  logic [7:0] curVec = '0;
  logic prevDtackN = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iack_vector_unit u0 (
    .clk(clk), .rstN(rstN), .asN(asN), .fc(fc), .addrHi(addrHi),
    .addrLo(addrLo), .avecN(avecN), .srcReq(srcReq), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .dataOut(dataOut),
    .dataOe(dataOe), .dtackN(dtackN), .ackPinN(ackPinN), .avecErr(avecErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic startCycle(input logic [2:0] f, input logic [3:0] ahi, input logic [2:0] lvl);
    @(posedge clk); #2;
    fc = f; addrHi = ahi; addrLo = lvl; asN = 1'b0;
    @(posedge clk); #3;   // detected at this edge; outputs now settled
  endtask

  // R6: release checked in the same cycle asN rises
  task automatic endCycle();
    @(posedge clk); #2;
    asN = 1'b1; fc = '0; addrHi = '0; addrLo = '0;
    #1;
    chk("R6 dtackN released", dtackN, 1);
    chk("R6 dataOe released", dataOe, 0);
    @(posedge clk); #2;
  endtask

  task automatic vecCycle(input logic [7:0] expVec);
    expQ.push_back(expVec);
    startCycle(3'b111, 4'hF, 3'd4);
    chk("R3 dtackN asserted", dtackN, 0);
    @(posedge clk); @(posedge clk);
    endCycle();
  endtask

  // Scoreboard monitor: pops one expected vector per DTACK assertion
  always @(negedge clk) begin
    if (rstN && !dtackN) begin
      if (prevDtackN) begin
        if (expQ.size() == 0) begin
          nCmp++; nBad++;
          $display("FAIL R2 unexpected vector act=%0h exp=none", dataOut);
          curVec = dataOut;
        end else begin
          curVec = expQ.pop_front();
        end
      end
      chk("R3/R4/R5 vector", dataOut, curVec);
      chk("R3 dataOe", dataOe, 1);
    end
    prevDtackN = dtackN;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 dtackN", dtackN, 1);
    chk("R1 dataOe", dataOe, 0);
    chk("R1 ackPinN", ackPinN, 3'b000);
    chk("R1 avecErr", avecErr, 0);

    // R1: base bits are 000 after reset; source 9 -> 0x09
    srcReq = 32'h0000_0200;
    vecCycle(8'h09);

    // R8/R3: base 101, sources 5 and 20 -> code 20
    regWrite(1'b0, 8'hA0);
    srcReq = (32'h1 << 5) | (32'h1 << 20);
    vecCycle(8'hB4);
    // R4: nothing pending
    srcReq = '0;
    vecCycle(8'hA0);
    // R3: bit 31 beats bit 0
    srcReq = 32'h8000_0001;
    vecCycle(8'hBF);

    // R5: capture at detect, srcReq changes mid-cycle
    srcReq = 32'h0000_0008;
    expQ.push_back(8'hA3);
    startCycle(3'b111, 4'hF, 3'd4);
    srcReq = 32'h4000_0000;
    @(posedge clk); @(posedge clk);
    endCycle();
    chk("R5 queue drained", expQ.size(), 0);

    // R2: wrong function code, wrong high address
    startCycle(3'b110, 4'hF, 3'd4);
    chk("R2 no dtack bad fc", dtackN, 1);
    chk("R2 no oe bad fc", dataOe, 0);
    endCycle();
    startCycle(3'b111, 4'hE, 3'd4);
    chk("R2 no dtack bad addr", dtackN, 1);
    endCycle();

    // R7: enable all strobes
    regWrite(1'b1, 8'h07);
    #1 chk("R7 idle pins high", ackPinN, 3'b111);
    startCycle(3'b111, 4'hF, 3'd7);
    chk("R7 level7 pin", ackPinN, 3'b011);
    chk("R7 level7 no dtack", dtackN, 1);
    chk("R7 level7 no oe", dataOe, 0);
    endCycle();
    chk("R7 pins after level7", ackPinN, 3'b111);
    startCycle(3'b111, 4'hF, 3'd1);
    chk("R7 level1 pin", ackPinN, 3'b110);
    endCycle();
    startCycle(3'b111, 4'hF, 3'd6);
    chk("R7 level6 pin", ackPinN, 3'b101);
    chk("R7 level6 no dtack", dtackN, 1);
    endCycle();

    // R9: other levels get nothing
    startCycle(3'b111, 4'hF, 3'd2);
    chk("R9 level2 pins", ackPinN, 3'b111);
    chk("R9 level2 dtack", dtackN, 1);
    endCycle();
    startCycle(3'b111, 4'hF, 3'd5);
    chk("R9 level5 oe", dataOe, 0);
    endCycle();

    // R8: all disabled, gpio 101
    regWrite(1'b1, 8'h28);
    #1 chk("R8 gpio pins", ackPinN, 3'b101);
    startCycle(3'b111, 4'hF, 3'd7);
    chk("R8 disabled pin ignores ack", ackPinN, 3'b101);
    endCycle();
    // R8: level7 enabled, others gpio
    regWrite(1'b1, 8'h2C);
    #1 chk("R8 mixed idle", ackPinN, 3'b101);
    startCycle(3'b111, 4'hF, 3'd7);
    chk("R8 mixed level7", ackPinN, 3'b001);
    endCycle();

    // R10: autovector during level 4 and level 7
    srcReq = '0;
    avecN = 1'b0;
    expQ.push_back(8'hA0);
    startCycle(3'b111, 4'hF, 3'd4);
    chk("R10 avecErr level4", avecErr, 1);
    @(posedge clk);
    endCycle();
    chk("R10 avecErr cleared", avecErr, 0);
    startCycle(3'b111, 4'hF, 3'd7);
    chk("R10 no avecErr level7", avecErr, 0);
    endCycle();
    avecN = 1'b1;

    repeat (3) @(posedge clk);
    chk("scoreboard empty", expQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule